// File: doc/BRIEF.md
# Fuse Word Program-and-Verify Sequencer

This block writes one 32-bit logical word into a one-time-programmable fuse array in which every logical word is held in two redundant physical rows. A single start pulse, carrying a 6-bit word index and the value to store, starts a fixed hardware sequence. The sequencer drives a fuse controller through a command port made of address, operation code and a one-cycle trigger, and it watches the controller's busy flag.

For each of the two rows, the sequencer powers the macro on and reads the row's present contents. It then programs, one bit per command, only those requested bits that are still unblown. Last, it checks the row with a margin read. After the second row it issues a refresh, and it pulses done once the refresh completes. It counts the rows that failed verification. The error flag is raised only when both copies are bad, because one good row still holds the word.

Operation codes on `cmd_op_o` are: 1 power-on, 2 array read, 3 margin read, 4 program bit, 5 refresh. The controller contract is as follows. Busy rises in the cycle after a trigger and stays high until that operation is complete. Read data is valid once busy has fallen after a read.

Top module: `fuse_word_prog_seq`

## Requirements
- R1: After reset, `cmd_valid_o`, `done_o`, `error_o` and `fail_cnt_o` are all zero.
- R2: Row (word<<1) is processed before row (word<<1)|1. For each row, a power-on (op 1, address 0) precedes an array read (op 2) at address (word<<1)|row.
- R3: The bits programmed in a row are exactly value AND NOT (array-read data). Each gets one program command (op 4), in ascending bit order, at address (bit<<7)|(word<<1)|row.
- R4: A row whose program set is empty gets no program command, but its margin read is still issued.
- R5: After the program phase of a row, a margin read (op 3) is issued at address (word<<1)|row. The row fails if (value AND margin data) differs from value.
- R6: After the second row's margin read, a refresh (op 5, address 0) is issued. `done_o` is a single-cycle pulse that follows once busy has cleared after the refresh.
- R7: `fail_cnt_o` holds the number of failed rows (0..2). `error_o` is 1 only when that count is 2. Both stay steady after done until the next accepted start, which clears them.
- R8: No command is triggered while busy is high, nor in the cycle right after a trigger. Every trigger is a one-cycle pulse.
- R9: A start pulse arriving while a sequence is in progress is ignored.
- R10: A row that fails verification does not stop the sequence: the second row and the refresh still follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only when idle |
| word_idx_i | input | 6 | Logical word index |
| value_i | input | 32 | Value to store |
| busy_i | input | 1 | Controller busy flag |
| rd_data_i | input | 32 | Controller read data |
| cmd_valid_o | output | 1 | Command trigger pulse |
| cmd_op_o | output | 3 | Operation code |
| cmd_addr_o | output | 12 | Command address |
| done_o | output | 1 | Sequence complete pulse |
| error_o | output | 1 | Both rows failed verification |
| fail_cnt_o | output | 2 | Number of failed rows |

## Verification
The bench builds the sequencer with its default parameters: a 32-bit data word, a 6-bit index and therefore a 12-bit address. It puts a behavioural controller with a three-cycle busy window and a stuck-bit fuse model behind the command port. Word 63 with bit 31 set drives every address bit high, so the top corner 0xFFF is checked. Stuck bits let one row or both rows fail verification, which exercises every value of the failure count.

// File: rtl/fuse_seq_pkg.sv
package fuse_seq_pkg;
  typedef enum logic [2:0] {
    OP_NONE      = 3'd0,
    OP_PWR_ON    = 3'd1,
    OP_ARRAY_RD  = 3'd2,
    OP_MARGIN_RD = 3'd3,
    OP_PROG      = 3'd4,
    OP_REFRESH   = 3'd5
  } fuse_op_e;

  typedef enum logic [1:0] {
    ADDR_ZERO = 2'd0,
    ADDR_ROW  = 2'd1,
    ADDR_BIT  = 2'd2
  } addr_sel_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_PWR,
    S_ARD,
    S_ARD_WAIT,
    S_PROG,
    S_MRD,
    S_MRD_WAIT,
    S_REF,
    S_REF_WAIT
  } seq_state_e;
endpackage

// File: rtl/fuse_bit_walker.sv
module fuse_bit_walker #(
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic              step_i,
  output logic              cur_set_o,
  output logic              last_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic [DATA_W-1:0] mask_q;
  logic [IDX_W-1:0]  idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      idx_q  <= '0;
    end else if (load_i) begin
      mask_q <= mask_i;
      idx_q  <= '0;
    end else if (step_i) begin
      idx_q  <= idx_q + 1'b1;
    end
  end

  assign cur_set_o = mask_q[idx_q];
  assign last_o    = (idx_q == IDX_W'(DATA_W - 1));
  assign idx_o     = idx_q;
endmodule

// File: rtl/fuse_cmd_addr.sv
module fuse_cmd_addr
  import fuse_seq_pkg::*;
#(
  parameter int WORD_W = 6,
  parameter int BIT_W  = 5,
  localparam int ADDR_W = BIT_W + WORD_W + 1
) (
  input  addr_sel_e         sel_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              row_i,
  input  logic [BIT_W-1:0]  bit_i,
  output logic [ADDR_W-1:0] addr_o
);
  always_comb begin
    unique case (sel_i)
      ADDR_ROW: addr_o = {{BIT_W{1'b0}}, word_i, row_i};
      ADDR_BIT: addr_o = {bit_i, word_i, row_i};
      default:  addr_o = '0;
    endcase
  end
endmodule

// File: rtl/fuse_verify_tally.sv
module fuse_verify_tally #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              judge_i,
  input  logic [DATA_W-1:0] expect_i,
  input  logic [DATA_W-1:0] readback_i,
  input  logic              finish_i,
  output logic [1:0]        fail_cnt_o,
  output logic              error_o
);
  logic [1:0] cnt_q;
  logic       err_q;
  logic       row_bad;

  assign row_bad = ((expect_i & readback_i) != expect_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else if (clear_i) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (judge_i && row_bad && cnt_q != 2'd3) cnt_q <= cnt_q + 2'd1;
      if (finish_i) err_q <= (cnt_q >= 2'd2);
    end
  end

  assign fail_cnt_o = cnt_q;
  assign error_o    = err_q;
endmodule

// File: rtl/fuse_word_prog_seq.sv
module fuse_word_prog_seq
  import fuse_seq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int WORD_W = 6,
  localparam int BIT_W  = $clog2(DATA_W),
  localparam int ADDR_W = BIT_W + WORD_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] word_idx_i,
  input  logic [DATA_W-1:0] value_i,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              cmd_valid_o,
  output logic [2:0]        cmd_op_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic              done_o,
  output logic              error_o,
  output logic [1:0]        fail_cnt_o
);
  seq_state_e        state_q, state_d;
  logic [WORD_W-1:0] word_q;
  logic [DATA_W-1:0] value_q;
  logic              row_q, row_d;
  logic              cmd_valid_q, done_q;
  fuse_op_e          cmd_op_q;
  logic [ADDR_W-1:0] cmd_addr_q;

  logic              ready;
  logic              issue, accept, walk_load, walk_step, judge, finish;
  fuse_op_e          issue_op;
  addr_sel_e         addr_sel;
  logic [ADDR_W-1:0] issue_addr;
  logic [DATA_W-1:0] prog_mask;
  logic              bit_set, bit_last;
  logic [BIT_W-1:0]  bit_idx;

  // one guard cycle after each trigger covers busy's rise latency
  assign ready     = !busy_i && !cmd_valid_q;
  assign prog_mask = value_q & ~rd_data_i;

  fuse_bit_walker #(.DATA_W(DATA_W)) u_walker (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (walk_load),
    .mask_i    (prog_mask),
    .step_i    (walk_step),
    .cur_set_o (bit_set),
    .last_o    (bit_last),
    .idx_o     (bit_idx)
  );

  fuse_cmd_addr #(.WORD_W(WORD_W), .BIT_W(BIT_W)) u_addr (
    .sel_i  (addr_sel),
    .word_i (word_q),
    .row_i  (row_q),
    .bit_i  (bit_idx),
    .addr_o (issue_addr)
  );

  fuse_verify_tally #(.DATA_W(DATA_W)) u_tally (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (accept),
    .judge_i    (judge),
    .expect_i   (value_q),
    .readback_i (rd_data_i),
    .finish_i   (finish),
    .fail_cnt_o (fail_cnt_o),
    .error_o    (error_o)
  );

  always_comb begin
    state_d   = state_q;
    row_d     = row_q;
    issue     = 1'b0;
    issue_op  = OP_NONE;
    addr_sel  = ADDR_ZERO;
    accept    = 1'b0;
    walk_load = 1'b0;
    walk_step = 1'b0;
    judge     = 1'b0;
    finish    = 1'b0;
    unique case (state_q)
      S_IDLE: if (start_i) begin
        accept  = 1'b1;
        row_d   = 1'b0;
        state_d = S_PWR;
      end
      S_PWR: if (ready) begin
        issue    = 1'b1;
        issue_op = OP_PWR_ON;
        state_d  = S_ARD;
      end
      S_ARD: if (ready) begin
        issue    = 1'b1;
        issue_op = OP_ARRAY_RD;
        addr_sel = ADDR_ROW;
        state_d  = S_ARD_WAIT;
      end
      S_ARD_WAIT: if (ready) begin
        walk_load = 1'b1;
        state_d   = (prog_mask == '0) ? S_MRD : S_PROG;
      end
      S_PROG: begin
        addr_sel = ADDR_BIT;
        if (!bit_set) begin
          walk_step = 1'b1;
        end else if (ready) begin
          issue     = 1'b1;
          issue_op  = OP_PROG;
          walk_step = 1'b1;
        end
        if (walk_step && bit_last) state_d = S_MRD;
      end
      S_MRD: if (ready) begin
        issue    = 1'b1;
        issue_op = OP_MARGIN_RD;
        addr_sel = ADDR_ROW;
        state_d  = S_MRD_WAIT;
      end
      S_MRD_WAIT: if (ready) begin
        judge = 1'b1;
        if (!row_q) begin
          row_d   = 1'b1;
          state_d = S_PWR;
        end else begin
          state_d = S_REF;
        end
      end
      S_REF: if (ready) begin
        issue    = 1'b1;
        issue_op = OP_REFRESH;
        state_d  = S_REF_WAIT;
      end
      S_REF_WAIT: if (ready) begin
        finish  = 1'b1;
        state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      row_q       <= 1'b0;
      word_q      <= '0;
      value_q     <= '0;
      cmd_valid_q <= 1'b0;
      cmd_op_q    <= OP_NONE;
      cmd_addr_q  <= '0;
      done_q      <= 1'b0;
    end else begin
      state_q     <= state_d;
      row_q       <= row_d;
      cmd_valid_q <= issue;
      done_q      <= finish;
      if (accept) begin
        word_q  <= word_idx_i;
        value_q <= value_i;
      end
      if (issue) begin
        cmd_op_q   <= issue_op;
        cmd_addr_q <= issue_addr;
      end
    end
  end

  assign cmd_valid_o = cmd_valid_q;
  assign cmd_op_o    = cmd_op_q;
  assign cmd_addr_o  = cmd_addr_q;
  assign done_o      = done_q;
endmodule

// File: rtl/fuse_word_prog_seq_chk.sv
module fuse_word_prog_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       busy_i,
  input logic       cmd_valid_o,
  input logic       done_o,
  input logic       error_o,
  input logic [1:0] fail_cnt_o
);
  // R8
  cmd_after_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> !$past(busy_i));

  // R8
  cmd_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);

  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R7
  error_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (error_o == (fail_cnt_o == 2'd2)));

  // R7
  fail_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_cnt_o != 2'd3);
endmodule

bind fuse_word_prog_seq fuse_word_prog_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_i      (busy_i),
  .cmd_valid_o (cmd_valid_o),
  .done_o      (done_o),
  .error_o     (error_o),
  .fail_cnt_o  (fail_cnt_o)
);

// File: tb/tb_fuse_word_prog_seq.sv
module tb_fuse_word_prog_seq;
  localparam int LAT = 3;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [5:0]  word_idx_i = '0;
  logic [31:0] value_i = '0;
  logic        busy_i = 1'b0;
  logic [31:0] rd_data_i = '0;
  logic        cmd_valid_o;
  logic [2:0]  cmd_op_o;
  logic [11:0] cmd_addr_o;
  logic        done_o, error_o;
  logic [1:0]  fail_cnt_o;

  int tests = 0, fails = 0;

  always #4 clk_i = ~clk_i;

  fuse_word_prog_seq dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .word_idx_i(word_idx_i),
    .value_i(value_i), .busy_i(busy_i), .rd_data_i(rd_data_i),
    .cmd_valid_o(cmd_valid_o), .cmd_op_o(cmd_op_o), .cmd_addr_o(cmd_addr_o),
    .done_o(done_o), .error_o(error_o), .fail_cnt_o(fail_cnt_o)
  );

  // controller and fuse model
  logic [31:0] fuse_mem [128];
  logic [31:0] stuck [128];
  logic [2:0]  log_op [160];
  logic [11:0] log_addr [160];
  int          log_n = 0, done_cnt = 0, viol = 0, lat_cnt = 0;
  logic        prev_valid = 1'b0;

  always @(posedge clk_i) begin
    if (done_o) done_cnt++;
    if (cmd_valid_o) begin
      if (busy_i || prev_valid) viol++;
      if (log_n < 160) begin
        log_op[log_n]   = cmd_op_o;
        log_addr[log_n] = cmd_addr_o;
      end
      log_n++;
      busy_i  <= 1'b1;
      lat_cnt <= LAT;
      case (cmd_op_o)
        3'd2, 3'd3: rd_data_i <= fuse_mem[cmd_addr_o[6:0]];
        3'd4: if (!stuck[cmd_addr_o[6:0]][cmd_addr_o[11:7]])
                fuse_mem[cmd_addr_o[6:0]][cmd_addr_o[11:7]] = 1'b1;
        default: ;
      endcase
    end else if (lat_cnt > 1) begin
      lat_cnt <= lat_cnt - 1;
    end else if (lat_cnt == 1) begin
      lat_cnt <= 0;
      busy_i  <= 1'b0;
    end
    prev_valid <= cmd_valid_o;
  end

  logic [2:0]  exp_op [160];
  logic [11:0] exp_addr [160];
  int          exp_n;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] expv);
    tests++;
    if (got !== expv) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, expv);
    end
  endtask

  task automatic clear_array();
    for (int i = 0; i < 128; i++) begin
      fuse_mem[i] = '0;
      stuck[i] = '0;
    end
  endtask

  task automatic push(input logic [2:0] op, input logic [11:0] addr);
    exp_op[exp_n] = op;
    exp_addr[exp_n] = addr;
    exp_n++;
  endtask

  // runs one word and checks command trace, rows, count, error (R2..R10)
  task automatic run_word(input logic [5:0] w, input logic [31:0] v, input bit inject, input string tag);
    logic [31:0] pre [2];
    logic [31:0] post [2];
    int efail;
    int cyc;
    int bad;
    exp_n = 0;
    efail = 0;
    for (int r = 0; r < 2; r++) begin
      logic [6:0]  ra;
      logic [31:0] zb;
      ra = {w, r[0]};
      pre[r] = fuse_mem[ra];
      zb = v & ~pre[r];
      push(3'd1, 12'h000);
      push(3'd2, {5'd0, ra});
      for (int b = 0; b < 32; b++)
        if (zb[b]) push(3'd4, {b[4:0], ra});
      push(3'd3, {5'd0, ra});
      post[r] = pre[r] | (zb & ~stuck[ra]);
      if ((v & post[r]) != v) efail++;
    end
    push(3'd5, 12'h000);

    log_n = 0;
    done_cnt = 0;
    viol = 0;
    @(negedge clk_i);
    start_i = 1'b1; word_idx_i = w; value_i = v;
    @(negedge clk_i);
    start_i = 1'b0;
    check({tag, " R7 cleared on start"}, {30'd0, fail_cnt_o}, 32'd0);
    cyc = 0;
    while (done_cnt == 0 && cyc < 4000) begin
      if (inject && cyc == 12) begin
        start_i = 1'b1; word_idx_i = w ^ 6'd1; value_i = ~v;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk_i);
      cyc++;
    end
    start_i = 1'b0;
    check({tag, " R6 done seen"}, done_cnt, 1);
    check({tag, " R7 fail count"}, {30'd0, fail_cnt_o}, efail);
    check({tag, " R7 error"}, {31'd0, error_o}, (efail == 2) ? 1 : 0);
    check({tag, " R2/R3/R4/R5/R6 command count"}, log_n, exp_n);
    bad = 0;
    for (int i = 0; i < exp_n && i < log_n; i++)
      if (bad == 0 && (log_op[i] !== exp_op[i] || log_addr[i] !== exp_addr[i])) begin
        bad = 1;
        check({tag, " R3 command trace"}, {17'd0, log_op[i], log_addr[i]},
              {17'd0, exp_op[i], exp_addr[i]});
      end
    if (bad == 0) check({tag, " R3 command trace"}, 0, 0);
    check({tag, " R2 row0 contents"}, fuse_mem[{w, 1'b0}], post[0]);
    check({tag, " R10 row1 contents"}, fuse_mem[{w, 1'b1}], post[1]);
    check({tag, " R8 busy respected"}, viol, 0);
    repeat (10) @(negedge clk_i);
    check({tag, " R6 single done pulse"}, done_cnt, 1);
    check({tag, " R7 count held"}, {30'd0, fail_cnt_o}, efail);
    check({tag, " R7 error held"}, {31'd0, error_o}, (efail == 2) ? 1 : 0);
  endtask

  task automatic t_reset();
    check("R1 cmd_valid", {31'd0, cmd_valid_o}, 0);
    check("R1 done", {31'd0, done_o}, 0);
    check("R1 error", {31'd0, error_o}, 0);
    check("R1 fail count", {30'd0, fail_cnt_o}, 0);
  endtask

  task automatic t_fresh();
    clear_array();
    run_word(6'd3, 32'hA5A5_0F0F, 1'b0, "fresh");
  endtask

  task automatic t_partial();
    clear_array();
    fuse_mem[20] = 32'h0000_FF00;
    fuse_mem[21] = 32'h8000_0001;
    run_word(6'd10, 32'h8001_FF81, 1'b0, "partial R3");
  endtask

  task automatic t_no_prog();
    clear_array();
    fuse_mem[8] = 32'hFFFF_0000;
    fuse_mem[9] = 32'h1234_5678;
    run_word(6'd4, 32'h1234_0000, 1'b0, "skip R4");
  endtask

  task automatic t_one_fail();
    clear_array();
    stuck[14] = 32'h0000_0010;
    run_word(6'd7, 32'h0000_00F0, 1'b0, "row0 bad R5");
  endtask

  task automatic t_both_fail();
    clear_array();
    stuck[30] = 32'h4000_0000;
    stuck[31] = 32'h0000_0002;
    run_word(6'd15, 32'h4000_0002, 1'b0, "both bad R7 R10");
  endtask

  task automatic t_ignore_start();
    clear_array();
    run_word(6'd21, 32'h0F00_00F0, 1'b1, "busy start R9");
    check("R9 other word untouched", fuse_mem[{6'd20, 1'b0}] | fuse_mem[{6'd20, 1'b1}], 32'd0);
  endtask

  task automatic t_top_corner();
    clear_array();
    run_word(6'd63, 32'h8000_0000, 1'b0, "corner R3");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    fails++;
    tests++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    clear_array();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_fresh();
    t_partial();
    t_no_prog();
    t_one_fail();
    t_both_fail();
    t_ignore_start();
    t_top_corner();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule